// File: doc/BRIEF.md
# Transfer Ring Doorbell Engine

This block is the device-side front end of a set of host-to-device work queues. Each logical channel owns one circular ring of fixed-size elements in memory. The host fills elements at its write index, advances that index, and then rings the channel's doorbell. The engine keeps one pending flag per channel. It picks pending channels in rotation and compares the channel's device read index with the host write index. When work is present, it fetches elements one at a time through a synchronous memory read port.

Elements may be chained. The engine collects one element after another until it reaches an element whose chain flag is clear. That completed transfer descriptor is reported as a single-cycle completion: the channel, the buffer address of the first element, the summed length, the element count and the new read index. The read index is advanced only when a descriptor completes. It wraps at the channel's ring size, which is a power of two set when the channel is configured. Moving payload data is not part of this block.

Top module: `xfer_ring_engine`

## Requirements
- R1: After a synchronous active-high reset, every ring base, size, write index and read index is zero, no doorbell is pending, and `cmp_valid` and `mem_ren` stay low until a doorbell arrives.
- R2: An element is `ELEM_W` bits wide. Bit 0 is the chain flag, bits [LEN_W:1] hold the length, and the top `BUFA_W` bits hold the buffer address. Element i of channel c is read from memory address base_c + i. `mem_rdata` is consumed in the cycle after the one in which `mem_ren` is high.
- R3: A doorbell on a channel whose read index equals its write index (an empty ring) clears that channel's pending flag. It causes no memory read and no completion.
- R4: A single element with its chain flag clear produces one completion with count 1, that element's length and address, and the channel number.
- R5: A descriptor ends at the first element whose chain flag is clear. Its completion reports the first element's buffer address, the sum of all lengths and the number of elements.
- R6: On completion, `cmp_rp` gives the new read index, one past the descriptor's last element. It wraps to 0 after index size-1.
- R7: Every descriptor between the read index and the write index is served after one doorbell. This includes a full ring, where write index + 1 equals read index modulo the size and size-1 elements are pending.
- R8: Pending channels are served one descriptor per turn, in ascending cyclic order starting after the channel served last. Channel 0 is first after reset.
- R9: If the write index is reached while a chain flag is still set, the engine reports nothing, leaves the read index unchanged and clears the pending flag. After the host extends the ring and rings the doorbell again, the whole descriptor is served from its first element.
- R10: Writing a write index without a doorbell starts no memory read.
- R11: At most one memory read is outstanding: `mem_ren` is never high in two consecutive cycles.
- R12: `cmp_valid` is a single-cycle pulse per descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CH_W | Channel addressed by the configuration write |
| cfg_field | input | 2 | Field select: 0 base, 1 log2 size, 2 write index, 3 read index |
| cfg_wdata | input | ADDR_W | Configuration write data |
| db_we | input | 1 | Doorbell strobe |
| db_ch | input | CH_W | Channel being rung |
| mem_ren | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read element address |
| mem_rdata | input | ELEM_W | Read data, valid one cycle after the request |
| cmp_valid | output | 1 | Descriptor completion pulse |
| cmp_ch | output | CH_W | Channel of the completed descriptor |
| cmp_addr | output | BUFA_W | Buffer address of the descriptor's first element |
| cmp_len | output | LEN_W+PTR_W | Summed length of the descriptor |
| cmp_count | output | PTR_W | Elements in the descriptor |
| cmp_rp | output | PTR_W | Read index after the descriptor |

## Verification
If the read index were wrong, completions would show the wrong first address, length or `cmp_rp` on the very next descriptor of that channel. An empty ring that was misjudged would produce a read on `mem_ren` within two cycles of the doorbell. A damaged rotation pointer shows up as a reordered completion sequence as soon as several channels are pending together. A mishandled chain shows up either as a count or summed length that differs from the scoreboard, or as a completion where none was due.

// File: rtl/xre_pkg.sv
package xre_pkg;
  typedef enum logic [1:0] {
    FLD_BASE = 2'd0,
    FLD_LG   = 2'd1,
    FLD_WP   = 2'd2,
    FLD_RP   = 2'd3
  } cfg_field_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_ISSUE = 2'd2,
    ST_DATA  = 2'd3
  } eng_state_e;
endpackage

// File: rtl/xre_ring_ctx.sv
module xre_ring_ctx
  import xre_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2,
  parameter int ADDR_W = 10,
  parameter int PTR_W  = 8,
  parameter int LG_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [1:0]        cfg_field,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              upd_en,
  input  logic [CH_W-1:0]   upd_ch,
  input  logic [PTR_W-1:0]  upd_rp,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [ADDR_W-1:0] rd_base,
  output logic [PTR_W-1:0]  rd_mask,
  output logic [PTR_W-1:0]  rd_wp,
  output logic [PTR_W-1:0]  rd_rp
);
  logic [ADDR_W-1:0] base_q [NUM_CH];
  logic [LG_W-1:0]   lg_q   [NUM_CH];
  logic [PTR_W-1:0]  wp_q   [NUM_CH];
  logic [PTR_W-1:0]  rp_q   [NUM_CH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CH; c++) begin
        base_q[c] <= '0;
        lg_q[c]   <= '0;
        wp_q[c]   <= '0;
        rp_q[c]   <= '0;
      end
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (cfg_we && cfg_ch == CH_W'(c)) begin
          case (cfg_field_e'(cfg_field))
            FLD_BASE: base_q[c] <= cfg_wdata;
            FLD_LG:   lg_q[c]   <= cfg_wdata[LG_W-1:0];
            FLD_WP:   wp_q[c]   <= cfg_wdata[PTR_W-1:0];
            default:  rp_q[c]   <= cfg_wdata[PTR_W-1:0];
          endcase
        end
        // the device's own read index update takes precedence
        if (upd_en && upd_ch == CH_W'(c)) rp_q[c] <= upd_rp;
      end
    end
  end

  always_comb begin
    rd_base = base_q[rd_ch];
    rd_wp   = wp_q[rd_ch];
    rd_rp   = rp_q[rd_ch];
    rd_mask = ~({PTR_W{1'b1}} << lg_q[rd_ch]);
  end
endmodule

// File: rtl/xre_db_latch.sv
module xre_db_latch #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              db_we,
  input  logic [CH_W-1:0]   db_ch,
  input  logic              clr_en,
  input  logic [CH_W-1:0]   clr_ch,
  output logic [NUM_CH-1:0] pend
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_bit
    logic set_b, clr_b;
    assign set_b = db_we && (db_ch == CH_W'(g));
    assign clr_b = clr_en && (clr_ch == CH_W'(g));
    always_ff @(posedge clk) begin
      if (rst)        pend[g] <= 1'b0;
      else if (set_b) pend[g] <= 1'b1;
      else if (clr_b) pend[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/xre_rr_arb.sv
module xre_rr_arb #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req,
  input  logic              take,
  output logic [NUM_CH-1:0] gnt,
  output logic [CH_W-1:0]   gnt_idx,
  output logic              any
);
  logic [CH_W-1:0] last_q;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int off = 1; off <= NUM_CH; off++) begin
      int c;
      c = (int'(last_q) + off) % NUM_CH;
      if (!any && req[c]) begin
        any     = 1'b1;
        gnt_idx = CH_W'(c);
        gnt[c]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       last_q <= CH_W'(NUM_CH - 1);
    else if (take) last_q <= gnt_idx;
  end
endmodule

// File: rtl/xre_fetch.sv
module xre_fetch
  import xre_pkg::*;
#(
  parameter int CH_W   = 2,
  parameter int ADDR_W = 10,
  parameter int PTR_W  = 8,
  parameter int LEN_W  = 16,
  parameter int BUFA_W = 32,
  localparam int ELEM_W = BUFA_W + LEN_W + 1,
  localparam int TOT_W  = LEN_W + PTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pend_any,
  input  logic [CH_W-1:0]   gnt_idx,
  output logic              take,
  output logic [CH_W-1:0]   sel_ch,
  input  logic [ADDR_W-1:0] ctx_base,
  input  logic [PTR_W-1:0]  ctx_mask,
  input  logic [PTR_W-1:0]  ctx_wp,
  input  logic [PTR_W-1:0]  ctx_rp,
  output logic              clr_en,
  output logic              upd_en,
  output logic [PTR_W-1:0]  upd_rp,
  output logic              mem_ren,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [ELEM_W-1:0] mem_rdata,
  output logic              cmp_valid,
  output logic [CH_W-1:0]   cmp_ch,
  output logic [BUFA_W-1:0] cmp_addr,
  output logic [TOT_W-1:0]  cmp_len,
  output logic [PTR_W-1:0]  cmp_count,
  output logic [PTR_W-1:0]  cmp_rp
);
  eng_state_e        state_q;
  logic [CH_W-1:0]   ch_q;
  logic [PTR_W-1:0]  wk_q;
  logic [TOT_W-1:0]  acc_q;
  logic [PTR_W-1:0]  cnt_q;
  logic [BUFA_W-1:0] first_q;

  logic              f_chain;
  logic [LEN_W-1:0]  f_len;
  logic [BUFA_W-1:0] f_addr;
  logic [PTR_W-1:0]  wk_nx;
  logic [TOT_W-1:0]  acc_nx;
  logic [PTR_W-1:0]  cnt_nx;
  logic              ring_empty;

  assign f_chain    = mem_rdata[0];
  assign f_len      = mem_rdata[LEN_W:1];
  assign f_addr     = mem_rdata[ELEM_W-1 -: BUFA_W];
  assign wk_nx      = (wk_q + PTR_W'(1)) & ctx_mask;
  assign acc_nx     = acc_q + TOT_W'(f_len);
  assign cnt_nx     = cnt_q + PTR_W'(1);
  assign ring_empty = (ctx_rp == ctx_wp);
  assign sel_ch     = ch_q;

  always_comb begin
    take   = (state_q == ST_IDLE) && pend_any;
    clr_en = ((state_q == ST_CHECK) && ring_empty) ||
             ((state_q == ST_DATA) && f_chain && (wk_nx == ctx_wp));
    upd_en = (state_q == ST_DATA) && !f_chain;
    upd_rp = wk_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      ch_q      <= '0;
      wk_q      <= '0;
      acc_q     <= '0;
      cnt_q     <= '0;
      first_q   <= '0;
      mem_ren   <= 1'b0;
      mem_addr  <= '0;
      cmp_valid <= 1'b0;
      cmp_ch    <= '0;
      cmp_addr  <= '0;
      cmp_len   <= '0;
      cmp_count <= '0;
      cmp_rp    <= '0;
    end else begin
      mem_ren   <= 1'b0;
      cmp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (pend_any) begin
            ch_q    <= gnt_idx;
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (ring_empty) begin
            state_q <= ST_IDLE;
          end else begin
            wk_q     <= ctx_rp;
            acc_q    <= '0;
            cnt_q    <= '0;
            mem_ren  <= 1'b1;
            mem_addr <= ctx_base + ADDR_W'(ctx_rp);
            state_q  <= ST_ISSUE;
          end
        end
        ST_ISSUE: state_q <= ST_DATA;
        default: begin
          acc_q <= acc_nx;
          cnt_q <= cnt_nx;
          if (cnt_q == '0) first_q <= f_addr;
          if (!f_chain) begin
            cmp_valid <= 1'b1;
            cmp_ch    <= ch_q;
            cmp_addr  <= (cnt_q == '0) ? f_addr : first_q;
            cmp_len   <= acc_nx;
            cmp_count <= cnt_nx;
            cmp_rp    <= wk_nx;
            state_q   <= ST_IDLE;
          end else if (wk_nx == ctx_wp) begin
            state_q <= ST_IDLE;
          end else begin
            wk_q     <= wk_nx;
            mem_ren  <= 1'b1;
            mem_addr <= ctx_base + ADDR_W'(wk_nx);
            state_q  <= ST_ISSUE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/xfer_ring_engine.sv
module xfer_ring_engine
  import xre_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 10,
  parameter int PTR_W  = 8,
  parameter int LEN_W  = 16,
  parameter int BUFA_W = 32,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int LG_W   = $clog2(PTR_W + 1),
  localparam int ELEM_W = BUFA_W + LEN_W + 1,
  localparam int TOT_W  = LEN_W + PTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [1:0]        cfg_field,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              db_we,
  input  logic [CH_W-1:0]   db_ch,
  output logic              mem_ren,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [ELEM_W-1:0] mem_rdata,
  output logic              cmp_valid,
  output logic [CH_W-1:0]   cmp_ch,
  output logic [BUFA_W-1:0] cmp_addr,
  output logic [TOT_W-1:0]  cmp_len,
  output logic [PTR_W-1:0]  cmp_count,
  output logic [PTR_W-1:0]  cmp_rp
);
  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] arb_gnt;
  logic [CH_W-1:0]   gnt_idx;
  logic              pend_any;
  logic              take;
  logic [CH_W-1:0]   sel_ch;
  logic [ADDR_W-1:0] ctx_base;
  logic [PTR_W-1:0]  ctx_mask, ctx_wp, ctx_rp;
  logic              clr_en, upd_en;
  logic [PTR_W-1:0]  upd_rp;

  xre_ring_ctx #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W), .LG_W(LG_W)
  ) u_ctx (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .upd_en(upd_en), .upd_ch(sel_ch), .upd_rp(upd_rp),
    .rd_ch(sel_ch), .rd_base(ctx_base), .rd_mask(ctx_mask),
    .rd_wp(ctx_wp), .rd_rp(ctx_rp)
  );

  xre_db_latch #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_db (
    .clk(clk), .rst(rst), .db_we(db_we), .db_ch(db_ch),
    .clr_en(clr_en), .clr_ch(sel_ch), .pend(pend)
  );

  xre_rr_arb #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_arb (
    .clk(clk), .rst(rst), .req(pend), .take(take),
    .gnt(arb_gnt), .gnt_idx(gnt_idx), .any(pend_any)
  );

  xre_fetch #(
    .CH_W(CH_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W), .LEN_W(LEN_W), .BUFA_W(BUFA_W)
  ) u_fetch (
    .clk(clk), .rst(rst),
    .pend_any(pend_any), .gnt_idx(gnt_idx), .take(take), .sel_ch(sel_ch),
    .ctx_base(ctx_base), .ctx_mask(ctx_mask), .ctx_wp(ctx_wp), .ctx_rp(ctx_rp),
    .clr_en(clr_en), .upd_en(upd_en), .upd_rp(upd_rp),
    .mem_ren(mem_ren), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .cmp_valid(cmp_valid), .cmp_ch(cmp_ch), .cmp_addr(cmp_addr),
    .cmp_len(cmp_len), .cmp_count(cmp_count), .cmp_rp(cmp_rp)
  );
endmodule

// File: rtl/xre_checker.sv
module xre_checker #(
  parameter int NUM_CH = 4,
  parameter int PTR_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmp_valid,
  input logic [PTR_W-1:0]  cmp_count,
  input logic              mem_ren,
  input logic [NUM_CH-1:0] gnt,
  input logic [NUM_CH-1:0] pend
);
  // R1: nothing is emitted in the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cmp_valid && !mem_ren));

  // R11: a read request is never followed directly by another
  a_r11_one_read_outstanding: assert property (@(posedge clk) disable iff (rst)
    mem_ren |=> !mem_ren);

  // R12: completion is a one-cycle pulse
  a_r12_cmp_single_pulse: assert property (@(posedge clk) disable iff (rst)
    cmp_valid |=> !cmp_valid);

  // R5: a descriptor always holds at least one element
  a_r5_count_nonzero: assert property (@(posedge clk) disable iff (rst)
    cmp_valid |-> (cmp_count != '0));

  // R8: at most one channel granted
  a_r8_grant_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  // R8: only a pending channel can be granted
  a_r8_grant_is_pending: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~pend) == '0);
endmodule

bind xfer_ring_engine xre_checker #(.NUM_CH(NUM_CH), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_count(cmp_count),
  .mem_ren(mem_ren), .gnt(arb_gnt), .pend(pend)
);

// File: tb/tb_xfer_ring_engine.sv
module tb_xfer_ring_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 10;
  localparam int PTR_W  = 8;
  localparam int LEN_W  = 16;
  localparam int BUFA_W = 32;
  localparam int CH_W   = 2;
  localparam int ELEM_W = BUFA_W + LEN_W + 1;
  localparam int TOT_W  = LEN_W + PTR_W;

  typedef struct packed {
    logic [CH_W-1:0]   ch;
    logic [BUFA_W-1:0] addr;
    logic [TOT_W-1:0]  len;
    logic [PTR_W-1:0]  cnt;
    logic [PTR_W-1:0]  rp;
  } cmp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [CH_W-1:0] cfg_ch = '0;
  logic [1:0] cfg_field = '0;
  logic [ADDR_W-1:0] cfg_wdata = '0;
  logic db_we = 1'b0;
  logic [CH_W-1:0] db_ch = '0;
  logic mem_ren;
  logic [ADDR_W-1:0] mem_addr;
  logic [ELEM_W-1:0] mem_rdata;
  logic cmp_valid;
  logic [CH_W-1:0] cmp_ch;
  logic [BUFA_W-1:0] cmp_addr;
  logic [TOT_W-1:0] cmp_len;
  logic [PTR_W-1:0] cmp_count, cmp_rp;

  int n_tests = 0;
  int n_fail = 0;
  int n_reads = 0;
  int cycles = 0;
  bit done = 1'b0;
  cmp_t exp_q[$];
  logic [ELEM_W-1:0] ram [1 << ADDR_W];

  always #(CLK_PERIOD / 2) clk = ~clk;

  xfer_ring_engine #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .PTR_W(PTR_W), .LEN_W(LEN_W), .BUFA_W(BUFA_W)
  ) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_field(cfg_field),
    .cfg_wdata(cfg_wdata), .db_we(db_we), .db_ch(db_ch),
    .mem_ren(mem_ren), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .cmp_valid(cmp_valid), .cmp_ch(cmp_ch), .cmp_addr(cmp_addr),
    .cmp_len(cmp_len), .cmp_count(cmp_count), .cmp_rp(cmp_rp)
  );

  // synchronous memory model, one cycle read latency (R2)
  always_ff @(posedge clk) if (mem_ren) mem_rdata <= ram[mem_addr];

  task automatic check(input bit ok, input string req, input string act, input string exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  function automatic logic [ELEM_W-1:0] elem(input logic [BUFA_W-1:0] a,
                                             input logic [LEN_W-1:0] l, input bit ch);
    return {a, l, ch};
  endfunction

  task automatic cfg(input int ch, input int fld, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = CH_W'(ch); cfg_field = 2'(fld); cfg_wdata = ADDR_W'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ring(input int ch);
    @(negedge clk);
    db_we = 1'b1; db_ch = CH_W'(ch);
    @(negedge clk);
    db_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic cmp_t mk(input int ch, input logic [BUFA_W-1:0] a,
                              input int l, input int c, input int rp);
    cmp_t e;
    e.ch = CH_W'(ch); e.addr = a; e.len = TOT_W'(l); e.cnt = PTR_W'(c); e.rp = PTR_W'(rp);
    return e;
  endfunction

  // monitor: pops the scoreboard on each completion
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_ren) n_reads++;
      if (cmp_valid) begin
        cmp_t got;
        got = {cmp_ch, cmp_addr, cmp_len, cmp_count, cmp_rp};
        if (exp_q.size() == 0) begin
          check(1'b0, "R3/R9 unexpected completion", $sformatf("%h", got), "none");
        end else begin
          cmp_t e;
          e = exp_q.pop_front();
          check(got == e, "R4/R5/R6/R8 completion", $sformatf("%h", got), $sformatf("%h", e));
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int r0;
    for (int i = 0; i < (1 << ADDR_W); i++) ram[i] = '0;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!cmp_valid && !mem_ren, "R1 outputs after reset",
          $sformatf("%b%b", cmp_valid, mem_ren), "00");
    // R1/R3: doorbell on unconfigured, empty ring
    ring(0); idle(10);
    check(n_reads == 0, "R1 R3 empty doorbell reads", $sformatf("%0d", n_reads), "0");

    cfg(0, 0, 'h000); cfg(0, 1, 2);
    cfg(1, 0, 'h100); cfg(1, 1, 3);
    cfg(2, 0, 'h200); cfg(2, 1, 2);
    cfg(3, 0, 'h300); cfg(3, 1, 1);

    // R10: write index without doorbell
    ram['h000] = elem(32'hA000_0000, 16'd64, 1'b0);
    cfg(0, 2, 1); idle(20);
    check(n_reads == 0, "R10 no read without doorbell", $sformatf("%0d", n_reads), "0");
    // R4 single element
    exp_q.push_back(mk(0, 32'hA000_0000, 64, 1, 1));
    ring(0); idle(15);
    check(n_reads == 1, "R2 R4 one read", $sformatf("%0d", n_reads), "1");
    // R3: ring emptied, doorbell again
    ring(0); idle(10);
    check(n_reads == 1, "R3 empty after service", $sformatf("%0d", n_reads), "1");

    // R5 chained descriptor on channel 1
    ram['h100] = elem(32'hB000_1000, 16'd10, 1'b1);
    ram['h101] = elem(32'hB000_2000, 16'd20, 1'b1);
    ram['h102] = elem(32'hB000_3000, 16'd30, 1'b0);
    cfg(1, 2, 3);
    exp_q.push_back(mk(1, 32'hB000_1000, 60, 3, 3));
    ring(1); idle(20);
    check(n_reads == 4, "R5 three element reads", $sformatf("%0d", n_reads), "4");

    // R6 R7 full ring with wrap on channel 0 (rp=1, wp=0)
    ram['h001] = elem(32'hC000_0001, 16'd5, 1'b0);
    ram['h002] = elem(32'hC000_0002, 16'd6, 1'b0);
    ram['h003] = elem(32'hC000_0003, 16'd7, 1'b0);
    cfg(0, 2, 0);
    exp_q.push_back(mk(0, 32'hC000_0001, 5, 1, 2));
    exp_q.push_back(mk(0, 32'hC000_0002, 6, 1, 3));
    exp_q.push_back(mk(0, 32'hC000_0003, 7, 1, 0));
    ring(0); idle(30);
    check(exp_q.size() == 0, "R7 full ring drained", $sformatf("%0d", exp_q.size()), "0");

    // R9 incomplete chain on channel 2
    r0 = n_reads;
    ram['h200] = elem(32'hD000_0000, 16'd100, 1'b1);
    cfg(2, 2, 1);
    ring(2); idle(20);
    check(n_reads == r0 + 1, "R9 partial chain reads", $sformatf("%0d", n_reads - r0), "1");
    ram['h201] = elem(32'hD000_0001, 16'd200, 1'b0);
    cfg(2, 2, 2);
    exp_q.push_back(mk(2, 32'hD000_0000, 300, 2, 2));
    ring(2); idle(20);
    check(n_reads == r0 + 3, "R9 restart from first element",
          $sformatf("%0d", n_reads - r0), "3");

    // R8 rotation across channels 3, 1, 0
    ram['h300] = elem(32'hE000_0000, 16'd1, 1'b0);
    cfg(3, 2, 1);
    ram['h000] = elem(32'hF000_0000, 16'd2, 1'b0);
    ram['h001] = elem(32'hF000_0001, 16'd3, 1'b1);
    ram['h002] = elem(32'hF000_0002, 16'd4, 1'b0);
    cfg(0, 2, 3);
    ram['h103] = elem(32'h6000_0003, 16'd9, 1'b0);
    cfg(1, 2, 4);
    exp_q.push_back(mk(3, 32'hE000_0000, 1, 1, 1));
    exp_q.push_back(mk(0, 32'hF000_0000, 2, 1, 1));
    exp_q.push_back(mk(1, 32'h6000_0003, 9, 1, 4));
    exp_q.push_back(mk(0, 32'hF000_0001, 7, 2, 3));
    @(negedge clk);
    db_we = 1'b1; db_ch = 2'd3;
    @(negedge clk);
    db_ch = 2'd1;
    @(negedge clk);
    db_ch = 2'd0;
    @(negedge clk);
    db_we = 1'b0;
    idle(60);
    check(exp_q.size() == 0, "R8 R7 all served", $sformatf("%0d", exp_q.size()), "0");
    check(!cmp_valid && !mem_ren, "R12 R11 quiet when idle",
          $sformatf("%b%b", cmp_valid, mem_ren), "00");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule